// File: doc/BRIEF.md
# Pushbutton Memory Pattern Checker

This block is a small controller that checks a memory user port end to end. Four pushbuttons, already debounced, are the input. Two buttons each write a fixed 128-bit pattern to their own location. One location is called primary and the other secondary. The other two buttons read a location back and compare all 128 bits with the pattern that belongs to it. Four single-colour LEDs show which button was last accepted. Two RGB LEDs show, for each location, whether it was written, whether the last read matched, or whether a read is still pending.

Every transfer carries eight 16-bit words in one user-clock cycle. The address names the lowest of the eight words. A command is held on the port until the port reports ready. Write data is presented with the write command. Read data is taken in the cycle the read-valid strobe is high.

The sequencer has four states:
- `ST_IDLE` waits for a button edge.
- `ST_WR_CMD` holds a write command until the port is ready, then returns to `ST_IDLE`.
- `ST_RD_CMD` holds a read command until the port is ready, then moves to `ST_RD_WAIT`.
- `ST_RD_WAIT` waits for read-valid, then returns to `ST_IDLE`.

Each location has a status register with four values: off, blue (written), green (read matched) and red (read mismatched).

Top module: `memchk_top`

## Requirements
- R1: During and directly after reset, `led` is 4'b1111, both RGB outputs are 3'b000 and `mem_cmd_en` is 0.
- R2: A rising edge on button i, accepted in `ST_IDLE`, sets `led` to only bit i on the next clock edge. A button that is held down does not start another command.
- R3: Button 0 issues a write (`mem_cmd_wr`=1) to `PRI_ADDR`. Once the port accepts it, `rgb_pri` becomes blue (3'b001).
- R4: Button 1 writes 0x5A0F repeated eight times to `SEC_ADDR`, and `rgb_sec` becomes blue. A write from button 0 carries 0x1234 repeated eight times.
- R5: Button 2 or 3 issues a read (`mem_cmd_wr`=0) of the primary or secondary address. From the accepting clock edge until read-valid, that location's RGB output is 3'b000 and its LED stays lit alone.
- R6: When read-valid arrives, the location's RGB output becomes green (3'b010) if all 128 bits equal its pattern. Otherwise it becomes red (3'b100), even when only a single bit differs.
- R7: A button edge that arrives outside `ST_IDLE` is ignored. It changes neither `led`, nor any RGB output, nor the command stream.
- R8: While `mem_cmd_en` is high and `mem_rdy` is low, the command, its type and its address stay unchanged.
- R9: When several buttons rise on the same edge, only the lowest-numbered one is accepted.
- R10: Each RGB output has bit 2 for red, bit 1 for green and bit 0 for blue. At most one bit is set at a time. Events for one location never change the other location's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn | input | 4 | Debounced buttons: 0 write primary, 1 write secondary, 2 read primary, 3 read secondary |
| mem_rdy | input | 1 | Memory port can take a command |
| mem_cmd_en | output | 1 | Command valid |
| mem_cmd_wr | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Lowest word address of the eight-word transfer |
| mem_wdata | output | DW | Write data, valid with the write command |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | DW | Read data |
| led | output | 4 | Single-colour LEDs |
| rgb_pri | output | 3 | Primary status {red, green, blue} |
| rgb_sec | output | 3 | Secondary status {red, green, blue} |

## Verification
A button edge that is present at a clock edge in `ST_IDLE` does three things at that edge: it updates `led`, raises `mem_cmd_en` and, for a read, clears that location's RGB. Blue appears at the edge where `mem_rdy` accepts a write. Green or red appears at the edge where `mem_rvalid` is high. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge, and every output is compared with it on the following falling edge, so each result is checked in exactly the cycle it is due. Directed checks are placed a fixed number of falling edges after each stimulus, inside the read latency window or after the transfer has settled.

// File: rtl/memchk_pkg.sv
package memchk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_CMD,
        ST_RD_CMD,
        ST_RD_WAIT
    } seq_state_t;

    localparam logic [2:0] RGB_OFF   = 3'b000;
    localparam logic [2:0] RGB_BLUE  = 3'b001;
    localparam logic [2:0] RGB_GREEN = 3'b010;
    localparam logic [2:0] RGB_RED   = 3'b100;
endpackage

// File: rtl/memchk_btn_edge.sv
module memchk_btn_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] btn,
    output logic [N-1:0] rise
);
    logic [N-1:0] btn_q;

    always_ff @(posedge clk) begin
        if (!rst_n) btn_q <= '0;
        else        btn_q <= btn;
    end

    assign rise = btn & ~btn_q;
endmodule

// File: rtl/memchk_seq.sv
module memchk_seq
    import memchk_pkg::*;
#(
    parameter int          DW       = 128,
    parameter int          WW       = 16,
    parameter int          AW       = 28,
    parameter logic [AW-1:0] PRI_ADDR = 28'h0000100,
    parameter logic [AW-1:0] SEC_ADDR = 28'h0000200,
    parameter logic [WW-1:0] PRI_WORD = 16'h1234,
    parameter logic [WW-1:0] SEC_WORD = 16'h5A0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    rise,
    input  logic          mem_rdy,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_cmd_en,
    output logic          mem_cmd_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [3:0]    led,
    output logic [1:0]    wr_done,
    output logic [1:0]    rd_start,
    output logic [1:0]    rd_done,
    output logic          rd_match
);
    localparam int NWORDS = DW / WW;
    localparam logic [DW-1:0] PRI_PAT = {NWORDS{PRI_WORD}};
    localparam logic [DW-1:0] SEC_PAT = {NWORDS{SEC_WORD}};

    seq_state_t state, state_nxt;
    logic       loc, loc_nxt;
    logic [1:0] pick;
    logic       any;
    logic [DW-1:0] pat;

    // lowest-numbered rising button wins
    always_comb begin
        any  = 1'b0;
        pick = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (rise[i]) begin
                any  = 1'b1;
                pick = 2'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            loc   <= 1'b0;
        end else begin
            state <= state_nxt;
            loc   <= loc_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        loc_nxt   = loc;
        unique case (state)
            ST_IDLE: begin
                if (any) begin
                    loc_nxt   = pick[0];
                    state_nxt = pick[1] ? ST_RD_CMD : ST_WR_CMD;
                end
            end
            ST_WR_CMD:  if (mem_rdy)    state_nxt = ST_IDLE;
            ST_RD_CMD:  if (mem_rdy)    state_nxt = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rvalid) state_nxt = ST_IDLE;
            default:                    state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        pat        = loc ? SEC_PAT : PRI_PAT;
        mem_cmd_en = (state == ST_WR_CMD) || (state == ST_RD_CMD);
        mem_cmd_wr = (state == ST_WR_CMD);
        mem_addr   = loc ? SEC_ADDR : PRI_ADDR;
        mem_wdata  = pat;
        rd_match   = (mem_rdata == pat);
        wr_done    = (state == ST_WR_CMD && mem_rdy) ? (2'b01 << loc) : 2'b00;
        rd_done    = (state == ST_RD_WAIT && mem_rvalid) ? (2'b01 << loc) : 2'b00;
        rd_start   = (state == ST_IDLE && any && pick[1]) ? (2'b01 << pick[0]) : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                      led <= 4'hF;
        else if (state == ST_IDLE && any) led <= 4'b0001 << pick;
    end

    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_en && !mem_rdy |=> mem_cmd_en && $stable(mem_addr) && $stable(mem_cmd_wr));

    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) && (rise != 4'b0) |=> $stable(led));

    assert_led_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (led == 4'hF) || $onehot(led));
endmodule

// File: rtl/memchk_rgb.sv
module memchk_rgb
    import memchk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_done,
    input  logic       rd_start,
    input  logic       rd_done,
    input  logic       rd_match,
    output logic [2:0] rgb
);
    always_ff @(posedge clk) begin
        if (!rst_n)        rgb <= RGB_OFF;
        else if (rd_start) rgb <= RGB_OFF;
        else if (wr_done)  rgb <= RGB_BLUE;
        else if (rd_done)  rgb <= rd_match ? RGB_GREEN : RGB_RED;
    end

    assert_rgb_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rgb));

    assert_green_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rgb[1]) |-> $past(rd_done && rd_match));

    assert_pending_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> rgb == RGB_OFF);
endmodule

// File: rtl/memchk_top.sv
module memchk_top
    import memchk_pkg::*;
#(
    parameter int          DW       = 128,
    parameter int          WW       = 16,
    parameter int          AW       = 28,
    parameter logic [AW-1:0] PRI_ADDR = 28'h0000100,
    parameter logic [AW-1:0] SEC_ADDR = 28'h0000200,
    parameter logic [WW-1:0] PRI_WORD = 16'h1234,
    parameter logic [WW-1:0] SEC_WORD = 16'h5A0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    btn,
    input  logic          mem_rdy,
    output logic          mem_cmd_en,
    output logic          mem_cmd_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic [3:0]    led,
    output logic [2:0]    rgb_pri,
    output logic [2:0]    rgb_sec
);
    localparam int NLOC = 2;

    logic [3:0]      rise;
    logic [NLOC-1:0] wr_done, rd_start, rd_done;
    logic            rd_match;
    logic [2:0]      rgb_arr [NLOC];

    memchk_btn_edge #(.N(4)) u_edge (
        .clk(clk), .rst_n(rst_n), .btn(btn), .rise(rise)
    );

    memchk_seq #(
        .DW(DW), .WW(WW), .AW(AW), .PRI_ADDR(PRI_ADDR), .SEC_ADDR(SEC_ADDR),
        .PRI_WORD(PRI_WORD), .SEC_WORD(SEC_WORD)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .rise(rise),
        .mem_rdy(mem_rdy), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_cmd_en(mem_cmd_en), .mem_cmd_wr(mem_cmd_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .led(led),
        .wr_done(wr_done), .rd_start(rd_start), .rd_done(rd_done), .rd_match(rd_match)
    );

    for (genvar g = 0; g < NLOC; g++) begin : g_loc
        memchk_rgb u_rgb (
            .clk(clk), .rst_n(rst_n),
            .wr_done(wr_done[g]), .rd_start(rd_start[g]),
            .rd_done(rd_done[g]), .rd_match(rd_match),
            .rgb(rgb_arr[g])
        );
    end

    assign rgb_pri = rgb_arr[0];
    assign rgb_sec = rgb_arr[1];
endmodule

// File: tb/memchk_top_tb_top.sv
module memchk_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 128;
    localparam int AW  = 28;
    localparam int LAT = 8;
    localparam logic [AW-1:0] PRI_A = 28'h0000100;
    localparam logic [AW-1:0] SEC_A = 28'h0000200;
    localparam logic [DW-1:0] PRI_P = {8{16'h1234}};
    localparam logic [DW-1:0] SEC_P = {8{16'h5A0F}};

    logic clk = 0, rst_n = 0;
    logic [3:0] btn = 0;
    logic mem_rdy = 1, mem_rvalid = 0;
    logic [DW-1:0] mem_rdata = '0;
    logic mem_cmd_en, mem_cmd_wr;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [3:0] led;
    logic [2:0] rgb_pri, rgb_sec;

    memchk_top dut_i (
        .clk(clk), .rst_n(rst_n), .btn(btn), .mem_rdy(mem_rdy),
        .mem_cmd_en(mem_cmd_en), .mem_cmd_wr(mem_cmd_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .led(led), .rgb_pri(rgb_pri), .rgb_sec(rgb_sec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    int phase = 0, mloc = 0, rdcnt = -1;
    logic [3:0] mbtnq = 0, mled = 4'hF;
    logic [2:0] mrgb [2] = '{3'b0, 3'b0};
    logic [DW-1:0] store [2] = '{'0, '0};
    logic [DW-1:0] flip = '0;
    bit stall = 0;

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            phase = 0; mbtnq = 0; mled = 4'hF; mrgb[0] = 0; mrgb[1] = 0; rdcnt = -1;
        end else begin
            logic [3:0] r;
            r = btn & ~mbtnq;
            mbtnq = btn;
            case (phase)
                0: if (r != 0) begin
                    int k;
                    k = 0;
                    while (!r[k]) k++;
                    mled = 4'b1 << k;
                    mloc = k % 2;
                    if (k < 2) phase = 1;
                    else begin phase = 2; mrgb[mloc] = 3'b000; end
                end
                1: if (mem_rdy) begin
                    store[mloc] = mloc ? SEC_P : PRI_P;
                    mrgb[mloc] = 3'b001; phase = 0;
                end
                2: if (mem_rdy) begin phase = 3; rdcnt = LAT; end
                default: if (mem_rvalid) begin
                    mrgb[mloc] = (mem_rdata == (mloc ? SEC_P : PRI_P)) ? 3'b010 : 3'b100;
                    phase = 0;
                end
            endcase
        end
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // compare, then drive the memory side, on each falling edge
    always @(negedge clk) begin
        logic ce;
        ce = (phase == 1) || (phase == 2);
        check(led == mled, rst_n ? "R2 led" : "R1 led", led, mled);
        check(rgb_pri == mrgb[0], "R6 rgb_pri", rgb_pri, mrgb[0]);
        check(rgb_sec == mrgb[1], "R10 rgb_sec", rgb_sec, mrgb[1]);
        check(mem_cmd_en == ce, "R8 cmd_en", mem_cmd_en, ce);
        if (ce) begin
            check(mem_cmd_wr == (phase == 1), "R3 cmd_wr", mem_cmd_wr, phase == 1);
            check(mem_addr == (mloc ? SEC_A : PRI_A), "R3 addr", mem_addr, mloc ? SEC_A : PRI_A);
            if (phase == 1)
                check(mem_wdata == (mloc ? SEC_P : PRI_P), "R4 wdata", mem_wdata, mloc ? SEC_P : PRI_P);
        end
        mem_rdy = stall ? (cyc % 3 == 2) : 1'b1;
        mem_rvalid = 0;
        if (rdcnt > 0) rdcnt--;
        else if (rdcnt == 0) begin
            mem_rvalid = 1;
            mem_rdata = store[mloc] ^ flip;
            rdcnt = -1;
        end
    end

    task automatic press(input logic [3:0] m);
        @(negedge clk); btn = m;
        repeat (3) @(negedge clk);
        btn = 0;
        repeat (LAT + 10) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(led == 4'hF && rgb_pri == 0 && rgb_sec == 0 && !mem_cmd_en, "R1 reset", {led, rgb_pri, rgb_sec}, 10'h3C0);
        rst_n = 1;
        @(negedge clk);
        check(led == 4'hF, "R1 after reset", led, 4'hF);

        press(4'b0100);  // read before any write
        check(rgb_pri == 3'b100, "R6 red on empty", rgb_pri, 3'b100);

        stall = 1;
        press(4'b0001);
        check(rgb_pri == 3'b001, "R3 pri blue", rgb_pri, 3'b001);
        press(4'b0010);
        check(rgb_sec == 3'b001, "R4 sec blue", rgb_sec, 3'b001);
        check(rgb_pri == 3'b001, "R10 pri untouched", rgb_pri, 3'b001);
        stall = 0;

        // R5 pending read, R7 press while busy
        @(negedge clk); btn = 4'b0100;
        repeat (3) @(negedge clk);
        check(rgb_pri == 3'b000, "R5 pending dark", rgb_pri, 3'b000);
        check(led == 4'b0100, "R5 pending led", led, 4'b0100);
        btn = 4'b1100;
        repeat (LAT + 8) @(negedge clk);
        btn = 0;
        repeat (3) @(negedge clk);
        check(rgb_sec == 3'b001, "R7 busy press ignored", rgb_sec, 3'b001);
        check(led == 4'b0100, "R7 led kept", led, 4'b0100);
        check(rgb_pri == 3'b010, "R6 pri green", rgb_pri, 3'b010);

        press(4'b1000);
        check(rgb_sec == 3'b010, "R6 sec green", rgb_sec, 3'b010);

        flip = 128'h1 << 77;
        press(4'b1000);
        check(rgb_sec == 3'b100, "R6 one-bit mismatch red", rgb_sec, 3'b100);
        flip = '0;

        press(4'b1010);
        check(led == 4'b0010, "R9 lowest wins", led, 4'b0010);
        check(rgb_sec == 3'b001, "R9 write taken", rgb_sec, 3'b001);

        @(negedge clk); btn = 4'b0001;
        repeat (20) @(negedge clk);
        check(!mem_cmd_en && led == 4'b0001, "R2 held no retrigger", {mem_cmd_en, led}, 5'b00001);
        btn = 0;
        repeat (5) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule